// File: doc/BRIEF.md
# Streaming Write Read-Allocate Detector

This block sits beside a write-back data cache that by default allocates a line on every read miss and every write miss. It watches the fill and write-out traffic and decides when allocating on write misses has stopped paying off. The typical case is a streaming store loop that overwrites whole lines. Each linefill it triggers fetches data that is discarded, because the core has already written every byte before the fill returns.

Each outstanding linefill buffer carries a line tag and a byte-written mask. When a fill completes, the block judges whether that line was fully overwritten. It counts such fills in an unbroken run. Once the run reaches a programmable threshold, it raises a registered read-allocate flag. While the flag is high, the cache keeps servicing loads with linefills and keeps looking up writes. A write that misses is sent to the next level as a write burst and starts no linefill.

The flag drops on either of two events. The first is a cacheable write burst that covers less than a full line. The second is a load whose line address matches the write burst currently in flight. Fills that were already in flight when the flag rose still complete, and the block absorbs them without effect.

Top module: `wr_alloc_guard`

## Requirements
- R1: After a synchronous active-low reset, `ra_mode` is 0, the streak count is 0, every fill buffer is idle and no write burst is recorded as in flight.
- R2: A `fill_start` on buffer b marks b busy with tag `fill_start_line` and clears its byte mask. A `store_valid` whose `store_line` equals the tag of a busy buffer ORs `store_byte_en` (bit i = byte i of the line) into that buffer's mask. This includes a store in the same cycle as the start when the lines match. A store to any other line leaves the mask unchanged.
- R3: A `fill_done` on a busy buffer whose mask is all ones is a full fill. Any same-cycle store hitting that buffer counts toward the mask. A full fill raises the streak by one, and the streak saturates at 15.
- R4: A `fill_done` on a busy buffer whose mask is not all ones resets the streak to 0. A `fill_done` on an idle buffer has no effect. Either kind of done frees the buffer.
- R5: When `ra_mode` is 0, `cfg_threshold` is nonzero and the updated streak is at least `cfg_threshold`, `ra_mode` is 1 in the next cycle and the streak is cleared.
- R6: While `cfg_threshold` is 0, `ra_mode` is 0 from the next cycle on, and read-allocate mode is never entered.
- R7: While `ra_mode` is 1, a `wburst_valid` with `wburst_cacheable`=1 and `wburst_full`=0 clears `ra_mode` and the streak in the next cycle. A full-line burst or a non-cacheable burst does not clear the flag.
- R8: Any `wburst_valid` records its line as in flight, and `wburst_done` (without a new burst) clears the record. While `ra_mode` is 1, a `load_valid` whose `load_line` equals the in-flight line recorded in an earlier cycle clears `ra_mode` and the streak in the next cycle.
- R9: While `ra_mode` is 1, fill completions, full or not, leave `ra_mode` at 1 and the streak at 0.
- R10: `ra_mode` is a register: every change appears in the cycle after the event that causes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_threshold | input | 4 | Run length of full fills needed to enter the mode; 0 disables it |
| fill_start | input | 1 | A linefill is being started |
| fill_start_buf | input | BUF_W | Fill buffer taking the new linefill |
| fill_start_line | input | LINE_W | Line address of the new linefill |
| store_valid | input | 1 | Core store merging into the line buffers |
| store_line | input | LINE_W | Line address of the store |
| store_byte_en | input | LINE_BYTES | Bytes of the line written by the store |
| fill_done | input | 1 | Linefill data has finished returning |
| fill_done_buf | input | BUF_W | Fill buffer whose linefill finished |
| wburst_valid | input | 1 | Write burst issued to the next level |
| wburst_line | input | LINE_W | Line address of the write burst |
| wburst_cacheable | input | 1 | The write burst is cacheable |
| wburst_full | input | 1 | The write burst covers the whole line |
| wburst_done | input | 1 | The in-flight write burst has finished |
| load_valid | input | 1 | Core load request |
| load_line | input | LINE_W | Line address of the load |
| ra_mode | output | 1 | Read-allocate mode: write misses do not allocate |

## Verification
Every event is presented for one clock, and its only visible result is `ra_mode` in the following cycle. A full fill, a partial fill, an exit burst and a matching load each show their effect one register stage later, and no event shows any effect in its own cycle. The bench drives inputs on the falling edge. A reference model then computes the value the flag must take at the coming rising edge, and the bench compares `ra_mode` against it at the next falling edge. This gives one check per cycle, with no extra latency allowed. Streak effects that the flag cannot show directly are made visible through the threshold. Examples are a reset after a partial fill, saturation at 15 and clearing on exit: the bench counts how many further full fills, or which threshold change, makes the flag rise.

// File: rtl/wag_pkg.sv
// Package wag_pkg
// Shared constants and helpers for the write read-allocate detector.
// Assumes the threshold and streak share one fixed 4-bit width.
package wag_pkg;
    localparam int THR_W = 4;
    typedef logic [THR_W-1:0] streak_t;
    localparam streak_t STREAK_MAX = '1;

    // Saturating increment of the consecutive-full-fill streak.
    function automatic streak_t streak_bump(streak_t s);
        return (s == STREAK_MAX) ? s : s + streak_t'(1);
    endfunction
endpackage

// File: rtl/wag_fill_slot.sv
// Module wag_fill_slot
// One linefill buffer: holds a busy bit, the line tag and a per-byte mask.
// The mask records which bytes the core wrote while the fill was outstanding.
// full_now reports, combinationally, whether the mask (plus any store hitting
// in this cycle) covers the whole line.
// Assumes at most one start and one done per slot per cycle; a start wins.
module wag_fill_slot #(
    parameter int LINE_W     = 26,
    parameter int LINE_BYTES = 64
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_sel,
    input  logic [LINE_W-1:0]     start_line,
    input  logic                  store_valid,
    input  logic [LINE_W-1:0]     store_line,
    input  logic [LINE_BYTES-1:0] store_byte_en,
    input  logic                  done_sel,
    output logic                  slot_busy,
    output logic                  full_now
);
    logic                  busy_q;
    logic [LINE_W-1:0]     tag_q;
    logic [LINE_BYTES-1:0] mask_q;
    logic                  hit_old;
    logic                  hit_new;
    logic [LINE_BYTES-1:0] hit_bytes;

    // Decode whether the store merges into the held line or a line starting now.
    always_comb begin
        hit_old   = store_valid && busy_q && (store_line == tag_q);
        hit_new   = store_valid && (store_line == start_line);
        hit_bytes = hit_old ? store_byte_en : '0;
        full_now  = busy_q && (&(mask_q | hit_bytes));
    end

    assign slot_busy = busy_q;

    // Allocate, merge store bytes into, or free the buffer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            tag_q  <= '0;
            mask_q <= '0;
        end else if (start_sel) begin
            busy_q <= 1'b1;
            tag_q  <= start_line;
            mask_q <= hit_new ? store_byte_en : '0;
        end else if (done_sel) begin
            busy_q <= 1'b0;
            mask_q <= '0;
        end else if (hit_old) begin
            mask_q <= mask_q | store_byte_en;
        end
    end

    // R2: a start leaves the slot busy with the requested tag.
    a_r2_start_tags: assert property (@(posedge clk) disable iff (!rst_n)
        start_sel |=> (busy_q && tag_q == $past(start_line)));

    // R4: a completion without a restart frees the slot.
    a_r4_done_frees: assert property (@(posedge clk) disable iff (!rst_n)
        (done_sel && !start_sel) |=> !busy_q);
endmodule

// File: rtl/wag_fill_tracker.sv
// Module wag_fill_tracker
// Holds NUM_BUFS fill slots and turns a fill_done on one of them into a
// completion event plus a full-line verdict for the mode controller.
// Assumes one fill_done per cycle; a done naming an idle buffer is no event.
module wag_fill_tracker #(
    parameter int NUM_BUFS   = 2,
    parameter int LINE_W     = 26,
    parameter int LINE_BYTES = 64,
    parameter int BUF_W      = 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  fill_start,
    input  logic [BUF_W-1:0]      fill_start_buf,
    input  logic [LINE_W-1:0]     fill_start_line,
    input  logic                  store_valid,
    input  logic [LINE_W-1:0]     store_line,
    input  logic [LINE_BYTES-1:0] store_byte_en,
    input  logic                  fill_done,
    input  logic [BUF_W-1:0]      fill_done_buf,
    output logic                  done_evt,
    output logic                  done_full
);
    logic [NUM_BUFS-1:0] start_sel;
    logic [NUM_BUFS-1:0] done_sel;
    logic [NUM_BUFS-1:0] busy;
    logic [NUM_BUFS-1:0] full;

    for (genvar b = 0; b < NUM_BUFS; b++) begin : g_slot
        assign start_sel[b] = fill_start && (fill_start_buf == BUF_W'(b));
        assign done_sel[b]  = fill_done  && (fill_done_buf  == BUF_W'(b));

        wag_fill_slot #(
            .LINE_W     (LINE_W),
            .LINE_BYTES (LINE_BYTES)
        ) u_slot (
            .clk           (clk),
            .rst_n         (rst_n),
            .start_sel     (start_sel[b]),
            .start_line    (fill_start_line),
            .store_valid   (store_valid),
            .store_line    (store_line),
            .store_byte_en (store_byte_en),
            .done_sel      (done_sel[b]),
            .slot_busy     (busy[b]),
            .full_now      (full[b])
        );
    end

    // Reduce the selected slot's state into one completion event.
    always_comb begin
        done_evt  = |(done_sel & busy);
        done_full = |(done_sel & full);
    end

    // R4: a full verdict only comes with a real completion.
    a_r4_full_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
        done_full |-> done_evt);
endmodule

// File: rtl/wag_burst_watch.sv
// Module wag_burst_watch
// Records the line of the write burst in flight to the next level and flags
// the two exit conditions: a cacheable partial-line burst, and a load to the
// recorded in-flight line. The load compares only against earlier bursts.
// Assumes one outstanding write burst is tracked; a new burst replaces it.
module wag_burst_watch #(
    parameter int LINE_W = 26
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wburst_valid,
    input  logic [LINE_W-1:0] wburst_line,
    input  logic              wburst_cacheable,
    input  logic              wburst_full,
    input  logic              wburst_done,
    input  logic              load_valid,
    input  logic [LINE_W-1:0] load_line,
    output logic              exit_partial,
    output logic              exit_load
);
    logic              inflight_q;
    logic [LINE_W-1:0] inflight_line_q;

    // Decode the exit requests for this cycle.
    always_comb begin
        exit_partial = wburst_valid && wburst_cacheable && !wburst_full;
        exit_load    = load_valid && inflight_q && (load_line == inflight_line_q);
    end

    // Track the line address of the most recent outstanding write burst.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inflight_q      <= 1'b0;
            inflight_line_q <= '0;
        end else if (wburst_valid) begin
            inflight_q      <= 1'b1;
            inflight_line_q <= wburst_line;
        end else if (wburst_done) begin
            inflight_q      <= 1'b0;
        end
    end

    // R8: an issued burst is recorded as in flight.
    a_r8_burst_recorded: assert property (@(posedge clk) disable iff (!rst_n)
        wburst_valid |=> (inflight_q && inflight_line_q == $past(wburst_line)));

    // R8: completion without a new burst clears the record.
    a_r8_burst_retired: assert property (@(posedge clk) disable iff (!rst_n)
        (wburst_done && !wburst_valid) |=> !inflight_q);
endmodule

// File: rtl/wag_mode_ctrl.sv
// Module wag_mode_ctrl
// Keeps the run of consecutive fully overwritten fills and the registered
// read-allocate flag. Exit requests take priority over everything; in the
// mode the streak is held at zero; a zero threshold forces normal allocate.
// Assumes done_evt/done_full and the exit requests are valid for this cycle.
module wag_mode_ctrl
    import wag_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [THR_W-1:0] cfg_threshold,
    input  logic             done_evt,
    input  logic             done_full,
    input  logic             exit_partial,
    input  logic             exit_load,
    output logic             ra_mode
);
    streak_t streak_q;
    streak_t streak_upd;
    logic    mode_q;
    logic    leave;
    logic    enter;

    // Compute the updated streak and the enter and leave decisions.
    always_comb begin
        leave = mode_q && (exit_partial || exit_load);
        if (done_evt) begin
            streak_upd = done_full ? streak_bump(streak_q) : '0;
        end else begin
            streak_upd = streak_q;
        end
        enter = !mode_q && (cfg_threshold != '0) && (streak_upd >= cfg_threshold);
    end

    // Register the flag and the streak.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q   <= 1'b0;
            streak_q <= '0;
        end else if (leave) begin
            mode_q   <= 1'b0;
            streak_q <= '0;
        end else if (mode_q) begin
            mode_q   <= (cfg_threshold != '0);
            streak_q <= '0;
        end else if (enter) begin
            mode_q   <= 1'b1;
            streak_q <= '0;
        end else begin
            streak_q <= streak_upd;
        end
    end

    assign ra_mode = mode_q;

    // R6: a zero threshold keeps the mode off.
    a_r6_zero_threshold_off: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_threshold == '0) |=> !ra_mode);

    // R7: a cacheable partial burst ends the mode.
    a_r7_partial_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (ra_mode && exit_partial) |=> !ra_mode);

    // R8: a load to the in-flight line ends the mode.
    a_r8_load_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (ra_mode && exit_load) |=> !ra_mode);

    // R3: the streak never wraps past its maximum.
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (!ra_mode && !exit_partial && !exit_load && streak_q == STREAK_MAX
         && done_evt && done_full) |=> (ra_mode || streak_q == STREAK_MAX));

    // R9: the streak stays cleared while the mode is on.
    a_r9_streak_held: assert property (@(posedge clk) disable iff (!rst_n)
        ra_mode |-> (streak_q == '0));

    // R5: the mode only rises with a nonzero threshold.
    a_r5_entry_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ra_mode) |-> ($past(cfg_threshold) != '0));
endmodule

// File: rtl/wr_alloc_guard.sv
// Module wr_alloc_guard
// Top of the streaming write read-allocate detector. It ties the fill
// tracker, the burst watcher and the mode controller together and exposes
// the registered read-allocate flag that steers write-miss allocation.
// Assumes events arrive as single-cycle pulses from the cache and bus unit.
module wr_alloc_guard
    import wag_pkg::*;
#(
    parameter int NUM_BUFS   = 2,
    parameter int LINE_W     = 26,
    parameter int LINE_BYTES = 64,
    localparam int BUF_W     = (NUM_BUFS > 1) ? $clog2(NUM_BUFS) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [THR_W-1:0]      cfg_threshold,
    input  logic                  fill_start,
    input  logic [BUF_W-1:0]      fill_start_buf,
    input  logic [LINE_W-1:0]     fill_start_line,
    input  logic                  store_valid,
    input  logic [LINE_W-1:0]     store_line,
    input  logic [LINE_BYTES-1:0] store_byte_en,
    input  logic                  fill_done,
    input  logic [BUF_W-1:0]      fill_done_buf,
    input  logic                  wburst_valid,
    input  logic [LINE_W-1:0]     wburst_line,
    input  logic                  wburst_cacheable,
    input  logic                  wburst_full,
    input  logic                  wburst_done,
    input  logic                  load_valid,
    input  logic [LINE_W-1:0]     load_line,
    output logic                  ra_mode
);
    logic done_evt;
    logic done_full;
    logic exit_partial;
    logic exit_load;

    wag_fill_tracker #(
        .NUM_BUFS   (NUM_BUFS),
        .LINE_W     (LINE_W),
        .LINE_BYTES (LINE_BYTES),
        .BUF_W      (BUF_W)
    ) u_tracker (
        .clk             (clk),
        .rst_n           (rst_n),
        .fill_start      (fill_start),
        .fill_start_buf  (fill_start_buf),
        .fill_start_line (fill_start_line),
        .store_valid     (store_valid),
        .store_line      (store_line),
        .store_byte_en   (store_byte_en),
        .fill_done       (fill_done),
        .fill_done_buf   (fill_done_buf),
        .done_evt        (done_evt),
        .done_full       (done_full)
    );

    wag_burst_watch #(
        .LINE_W (LINE_W)
    ) u_burst (
        .clk              (clk),
        .rst_n            (rst_n),
        .wburst_valid     (wburst_valid),
        .wburst_line      (wburst_line),
        .wburst_cacheable (wburst_cacheable),
        .wburst_full      (wburst_full),
        .wburst_done      (wburst_done),
        .load_valid       (load_valid),
        .load_line        (load_line),
        .exit_partial     (exit_partial),
        .exit_load        (exit_load)
    );

    wag_mode_ctrl u_mode (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_threshold (cfg_threshold),
        .done_evt      (done_evt),
        .done_full     (done_full),
        .exit_partial  (exit_partial),
        .exit_load     (exit_load),
        .ra_mode       (ra_mode)
    );

    // R10: the flag only moves on a clock edge after reset.
    a_r10_flag_after_reset: assert property (@(posedge clk)
        !rst_n |=> !ra_mode);
endmodule

// File: tb/wr_alloc_guard_bench.sv
module wr_alloc_guard_bench;
    localparam int NB = 2;
    localparam int LW = 26;
    localparam int LB = 64;
    localparam int BW = 1;
    localparam logic [LB-1:0] ALL = '1;
    localparam logic [LB-1:0] LO  = {{(LB/2){1'b0}}, {(LB/2){1'b1}}};
    localparam logic [LB-1:0] HI  = {{(LB/2){1'b1}}, {(LB/2){1'b0}}};

    logic          clk = 1'b0;
    logic          rst_n;
    logic [3:0]    thr;
    logic          fs;  logic [BW-1:0] fs_b;  logic [LW-1:0] fs_a;
    logic          st;  logic [LW-1:0] st_a;  logic [LB-1:0] st_be;
    logic          fd;  logic [BW-1:0] fd_b;
    logic          wb;  logic [LW-1:0] wb_a;  logic wb_c, wb_f, wb_d;
    logic          ld;  logic [LW-1:0] ld_a;
    logic          ra_mode;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    // Reference model state
    bit            m_busy [NB];
    logic [LW-1:0] m_tag  [NB];
    logic [LB-1:0] m_mask [NB];
    int            m_streak;
    bit            m_mode;
    bit            m_inf;
    logic [LW-1:0] m_inf_a;

    always #10 clk = ~clk;

    wr_alloc_guard u_wr_alloc_guard (
        .clk(clk), .rst_n(rst_n), .cfg_threshold(thr),
        .fill_start(fs), .fill_start_buf(fs_b), .fill_start_line(fs_a),
        .store_valid(st), .store_line(st_a), .store_byte_en(st_be),
        .fill_done(fd), .fill_done_buf(fd_b),
        .wburst_valid(wb), .wburst_line(wb_a), .wburst_cacheable(wb_c),
        .wburst_full(wb_f), .wburst_done(wb_d),
        .load_valid(ld), .load_line(ld_a), .ra_mode(ra_mode)
    );

    function automatic int bump(int s);
        return (s >= 15) ? 15 : s + 1;
    endfunction

    task automatic quiet();
        fs = 0; fs_b = 0; fs_a = 0; st = 0; st_a = 0; st_be = 0;
        fd = 0; fd_b = 0; wb = 0; wb_a = 0; wb_c = 0; wb_f = 0; wb_d = 0;
        ld = 0; ld_a = 0;
    endtask

    task automatic model_reset();
        for (int b = 0; b < NB; b++) begin
            m_busy[b] = 0; m_tag[b] = 0; m_mask[b] = 0;
        end
        m_streak = 0; m_mode = 0; m_inf = 0; m_inf_a = 0;
    endtask

    // Next state of the reference model from the inputs currently driven.
    task automatic model_step();
        bit   dev, dfull, leave;
        int   s;
        logic [LB-1:0] hb;
        dev = fd && m_busy[fd_b];
        hb  = (st && m_busy[fd_b] && m_tag[fd_b] == st_a) ? st_be : '0;
        dfull = dev && (&(m_mask[fd_b] | hb));
        leave = m_mode && ((wb && wb_c && !wb_f) || (ld && m_inf && ld_a == m_inf_a));
        for (int b = 0; b < NB; b++) begin
            if (fs && fs_b == b) begin
                m_busy[b] = 1; m_tag[b] = fs_a;
                m_mask[b] = (st && st_a == fs_a) ? st_be : '0;
            end else if (fd && fd_b == b) begin
                m_busy[b] = 0; m_mask[b] = 0;
            end else if (m_busy[b] && st && st_a == m_tag[b]) begin
                m_mask[b] = m_mask[b] | st_be;
            end
        end
        if (leave) begin
            m_mode = 0; m_streak = 0;
        end else if (m_mode) begin
            m_mode = (thr != 0); m_streak = 0;
        end else begin
            s = dev ? (dfull ? bump(m_streak) : 0) : m_streak;
            if (thr != 0 && s >= thr) begin
                m_mode = 1; m_streak = 0;
            end else m_streak = s;
        end
        if (wb) begin
            m_inf = 1; m_inf_a = wb_a;
        end else if (wb_d) m_inf = 0;
    endtask

    task automatic check(string tag, bit exp);
        checks++;
        if (ra_mode !== exp) begin
            errors++;
            $display("FAIL %s: ra_mode actual=%0b expected=%0b at %0t", tag, ra_mode, exp, $time);
        end
    endtask

    // One cycle: inputs already driven after a falling edge; result checked
    // at the next falling edge, one register stage after the edge.
    task automatic tick(string tag);
        model_step();
        @(posedge clk);
        @(negedge clk);
        check(tag, m_mode);
        quiet();
    endtask

    task automatic fill_split(int b, logic [LW-1:0] a, string tag);
        fs = 1; fs_b = BW'(b); fs_a = a; tick(tag);
        st = 1; st_a = a; st_be = LO; tick(tag);
        st = 1; st_a = a; st_be = HI; tick(tag);
        fd = 1; fd_b = BW'(b); tick(tag);
    endtask

    task automatic fill_quick(int b, logic [LW-1:0] a, string tag);
        fs = 1; fs_b = BW'(b); fs_a = a; st = 1; st_a = a; st_be = ALL; tick(tag);
        fd = 1; fd_b = BW'(b); tick(tag);
    endtask

    task automatic fill_partial(int b, logic [LW-1:0] a, string tag);
        fs = 1; fs_b = BW'(b); fs_a = a; tick(tag);
        st = 1; st_a = a; st_be = LO; tick(tag);
        fd = 1; fd_b = BW'(b); tick(tag);
    endtask

    initial begin
        #(20 * 200000);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2718));
        quiet(); thr = 4'd3; rst_n = 0;
        model_reset();
        repeat (3) @(negedge clk);
        check("R1 reset", 1'b0);
        rst_n = 1;

        // R1/R4: streak starts at zero; partial fill breaks the run
        fill_split(0, 26'h10, "R2 split stores");
        fill_split(1, 26'h11, "R3 second full");
        check("R1 streak from zero", 1'b0);
        fill_partial(0, 26'h12, "R4 partial resets");
        fill_quick(0, 26'h13, "R4 after reset 1");
        fill_quick(1, 26'h14, "R4 after reset 2");
        check("R4 streak restarted", 1'b0);
        fs = 1; fs_b = 0; fs_a = 26'h15; tick("R10");
        st = 1; st_a = 26'h15; st_be = ALL; tick("R10");
        fd = 1; fd_b = 0;
        check("R10 no change before edge", 1'b0);
        tick("R5 entry on third");
        check("R5 mode entered", 1'b1);

        // R9: fills in mode change nothing; R7 non-exit bursts
        fill_quick(1, 26'h16, "R9 fill in mode");
        fill_partial(0, 26'h17, "R9 partial in mode");
        check("R9 still in mode", 1'b1);
        wb = 1; wb_a = 26'h20; wb_c = 1; wb_f = 1; tick("R7 full burst keeps");
        wb = 1; wb_a = 26'h21; wb_c = 0; wb_f = 0; tick("R7 noncacheable keeps");
        check("R7 still in mode", 1'b1);
        wb = 1; wb_a = 26'h22; wb_c = 1; wb_f = 0; tick("R7 partial exits");
        check("R7 exited", 1'b0);

        // R7 streak cleared on exit; R2 store to other line does not count
        thr = 4'd2;
        fill_quick(0, 26'h30, "R7 count cleared");
        check("R7 one fill not enough", 1'b0);
        fs = 1; fs_b = 1; fs_a = 26'h31; st = 1; st_a = 26'h32; st_be = ALL; tick("R2 other line");
        fd = 1; fd_b = 1; tick("R2 other line done");
        fill_quick(0, 26'h33, "R2 after miss 1");
        check("R2 foreign store ignored", 1'b0);
        fill_quick(1, 26'h34, "R5 threshold two");
        check("R5 entered at two", 1'b1);

        // R8: load exits only on the in-flight line
        wb = 1; wb_a = 26'h40; wb_c = 1; wb_f = 1; tick("R8 burst");
        ld = 1; ld_a = 26'h41; tick("R8 other load");
        check("R8 other line keeps", 1'b1);
        wb_d = 1; tick("R8 burst done");
        ld = 1; ld_a = 26'h40; tick("R8 retired line");
        check("R8 retired burst keeps", 1'b1);
        wb = 1; wb_a = 26'h42; wb_c = 1; wb_f = 1; ld = 1; ld_a = 26'h42; tick("R8 same cycle");
        check("R8 same-cycle load keeps", 1'b1);
        ld = 1; ld_a = 26'h42; tick("R8 load hit exits");
        check("R8 exited", 1'b0);

        // R6 zero threshold; R3 saturation seen through a threshold raise
        fill_quick(0, 26'h50, "R6 prep 1");
        fill_quick(1, 26'h51, "R6 prep 2");
        thr = 4'd0; tick("R6 zero clears");
        check("R6 mode off", 1'b0);
        for (int i = 0; i < 17; i++) fill_quick(i % 2, LW'(26'h60 + i), "R6 no entry");
        check("R6 never entered", 1'b0);
        thr = 4'd15; tick("R3 saturated at 15");
        check("R3 saturated entry", 1'b1);

        // R4: done on idle buffer ignored
        thr = 4'd1;
        wb = 1; wb_a = 26'h70; wb_c = 1; wb_f = 0; tick("R4 exit");
        fd = 1; fd_b = 1; tick("R4 idle done");
        tick("R4 idle done after");
        check("R4 idle done no effect", 1'b0);

        // Constrained random phase against the model
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(0, 99) < 3) thr = 4'($urandom_range(0, 4));
            fs = ($urandom_range(0, 99) < 30); fs_b = BW'($urandom_range(0, 1));
            fs_a = LW'($urandom_range(0, 3));
            st = ($urandom_range(0, 99) < 60); st_a = LW'($urandom_range(0, 3));
            case ($urandom_range(0, 3))
                0: st_be = ALL;
                1: st_be = LO;
                2: st_be = HI;
                default: st_be = {$urandom, $urandom};
            endcase
            fd = ($urandom_range(0, 99) < 30); fd_b = BW'($urandom_range(0, 1));
            wb = ($urandom_range(0, 99) < 12); wb_a = LW'($urandom_range(0, 3));
            wb_c = ($urandom_range(0, 3) != 0); wb_f = ($urandom_range(0, 2) != 0);
            wb_d = ($urandom_range(0, 99) < 20);
            ld = ($urandom_range(0, 99) < 20); ld_a = LW'($urandom_range(0, 3));
            tick("R3 random");
        end

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule